// File: doc/BRIEF.md
# Two-Level Bus Grant Arbiter

This block decides which requester may drive a bus in a system with two buses joined by a central bridge. It has two levels. The first level holds one arbiter per bus for transfers that stay on that bus. Each of these has a round-robin group for requesters of equal rank and, below it, a fixed-rank group for requesters of distinct, lower rank. The second level is one arbiter shared by both buses for transfers that cross the bridge. It is built the same way, over the requesters of both buses.

The two bus arbiters run independently, so each bus can have a granted transfer at the same time. The cross-bus arbiter starts a grant only when neither bus has a local request pending. Because it is a single arbiter for both directions, two crossing transfers in opposite directions can never both be granted. Each bus has a burst-hold input, raised by the current master for the length of a burst. While it is high, that bus grants no new requester, and the cross-bus level is held off as well. Group sizes are parameters.

Top module: `hier_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every grant output and sets every round-robin pointer to index 0, so the first round-robin grant after reset goes to the lowest-indexed requesting member.
- R2: Within a round-robin group, a new grant goes to the first requesting member found by scanning upward from the pointer and wrapping past the top. After a grant to member i, the pointer becomes i+1, or 0 past the top.
- R3: The round-robin pointer changes only in a cycle where that arbiter issues a new round-robin grant. Blocked cycles and held grants leave it unchanged.
- R4: Requester indices 0 to BUS_RR-1 of a bus form its round-robin group, and indices BUS_RR to BUS_RR+BUS_FX-1 form its fixed group. Within the fixed group, the lowest requesting index wins.
- R5: A fixed-group requester receives a new grant only when no round-robin member of the same arbiter is requesting.
- R6: A grant stays on its requester for as long as that request stays high. In the cycle the request is low, another requester can be granted at the same clock edge.
- R7: Each grant output is one-hot or zero.
- R8: The two bus arbiters are independent. Both can hold a grant in the same cycle, and a burst hold on one bus does not affect the other bus.
- R9: The cross-bus level arbitrates xreq, where bit i < N is bus A requester i and bit N+i is bus B requester i. Bits 0 to EXT_RR-1 form its round-robin group and the remaining bits form its fixed group, lowest index first.
- R10: The cross-bus level issues a new grant only when no bit of req_a or req_b is set. A cross-bus grant that is already active is kept while its request holds.
- R11: While burst_hold[0] (bus A) or burst_hold[1] (bus B) is high, that bus arbiter issues no new grant and a held grant is kept only while its request holds. Either hold bit also stops new cross-bus grants.
- R12: Grants are registered. A request change is first seen on the grant outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | BUS_RR+BUS_FX | Local requests on bus A |
| req_b | input | BUS_RR+BUS_FX | Local requests on bus B |
| xreq | input | 2*(BUS_RR+BUS_FX) | Cross-bus requests, bus A members low, bus B members high |
| burst_hold | input | 2 | Burst hold per bus: bit 0 bus A, bit 1 bus B |
| gnt_a | output | BUS_RR+BUS_FX | One-hot local grant, bus A |
| gnt_b | output | BUS_RR+BUS_FX | One-hot local grant, bus B |
| xgnt | output | 2*(BUS_RR+BUS_FX) | One-hot cross-bus grant |

## Verification
The hardest condition to reach is a round-robin pointer that has been left alone. This happens when requests are present but a burst hold or a held grant stops any new grant, and it can only be seen later, through which member wins next. The stimulus sets a known pointer, raises all round-robin requests with the hold asserted for two cycles, then drops the hold and checks that the winner matches the old pointer. A second hard case is a cross-bus grant that must survive a new local request. For this, the bench first lets the crossing request win on idle buses and then raises a local request while the crossing request stays high.

// File: rtl/hier_bus_arb_pkg.sv
package hier_bus_arb_pkg;

  localparam int SCAN_MAX = 32;

  // step an index forward by one inside [0, lim)
  function automatic int wrap_inc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // position of the set bit of a one-hot word (0 for an empty word)
  function automatic int oh_index(input logic [SCAN_MAX-1:0] v);
    int r;
    r = 0;
    for (int i = 0; i < SCAN_MAX; i++)
      if (v[i]) r = i;
    return r;
  endfunction

  // rotating scan: first set bit at or above start, wrapping inside w bits
  function automatic logic [SCAN_MAX-1:0] rr_scan(input logic [SCAN_MAX-1:0] req,
                                                  input int w, input int start);
    logic [SCAN_MAX-1:0] hit;
    int idx;
    logic found;
    hit = '0;
    found = 1'b0;
    idx = start;
    for (int k = 0; k < SCAN_MAX; k++) begin
      if (k < w) begin
        if (!found && req[idx]) begin
          hit[idx] = 1'b1;
          found = 1'b1;
        end
        idx = wrap_inc(idx, w);
      end
    end
    return hit;
  endfunction

  // lowest set bit wins
  function automatic logic [SCAN_MAX-1:0] low_first(input logic [SCAN_MAX-1:0] req);
    return req & (~req + 1'b1);
  endfunction

endpackage

// File: rtl/rr_group.sv
module rr_group #(
  parameter int W  = 3,
  parameter int PW = 2
) (
  input  logic [W-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic [W-1:0]  pick_o,
  output logic          any_o
);
  import hier_bus_arb_pkg::*;

  logic [SCAN_MAX-1:0] scan_w;

  always_comb begin
    scan_w = rr_scan(SCAN_MAX'(req_i), W, int'(ptr_i));
    pick_o = scan_w[W-1:0];
    any_o  = |req_i;
  end

  always_comb begin
    assert (!any_o || $countones(pick_o) == 1)
      else $error("rr_group: request without exactly one pick");
  end

endmodule

// File: rtl/fix_group.sv
module fix_group #(
  parameter int W = 2
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] pick_o,
  output logic         any_o
);
  import hier_bus_arb_pkg::*;

  logic [SCAN_MAX-1:0] low_w;

  always_comb begin
    low_w  = low_first(SCAN_MAX'(req_i));
    pick_o = low_w[W-1:0];
    any_o  = |req_i;
  end

endmodule

// File: rtl/grp_arb.sv
module grp_arb #(
  parameter int NRR = 3,
  parameter int NFX = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NRR+NFX-1:0]   req_i,
  input  logic                 block_i,
  output logic [NRR+NFX-1:0]   gnt_o
);
  import hier_bus_arb_pkg::*;

  localparam int N  = NRR + NFX;
  localparam int PW = (NRR > 1) ? $clog2(NRR) : 1;

  logic [N-1:0]   gnt_q;
  logic [PW-1:0]  ptr_q;
  logic [NRR-1:0] rr_req, rr_pick;
  logic [NFX-1:0] fx_req, fx_pick;
  logic           rr_any, fx_any;
  logic [N-1:0]   cand;
  logic           hold_w;
  logic           issue_w;
  logic [PW-1:0]  ptr_next;

  assign rr_req = req_i[NRR-1:0];
  assign fx_req = req_i[N-1:NRR];

  rr_group #(.W(NRR), .PW(PW)) u_rr (
    .req_i (rr_req),
    .ptr_i (ptr_q),
    .pick_o(rr_pick),
    .any_o (rr_any)
  );

  fix_group #(.W(NFX)) u_fx (
    .req_i (fx_req),
    .pick_o(fx_pick),
    .any_o (fx_any)
  );

  // two-input fixed stage: round-robin group outranks the fixed group
  always_comb begin
    cand = '0;
    if (rr_any) cand[NRR-1:0] = rr_pick;
    else        cand[N-1:NRR] = fx_pick;
  end

  assign hold_w   = |(gnt_q & req_i);
  assign issue_w  = !hold_w && !block_i && (rr_any || fx_any);
  assign ptr_next = PW'(wrap_inc(oh_index(SCAN_MAX'(rr_pick)), NRR));

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
      ptr_q <= '0;
    end else if (hold_w) begin
      gnt_q <= gnt_q;
    end else if (issue_w) begin
      gnt_q <= cand;
      if (rr_any) ptr_q <= ptr_next;
    end else begin
      gnt_q <= '0;
    end
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)) else $error("grant not one-hot"); // R7

  AST_GNT_HELD: assert property (@(posedge clk) disable iff (rst)
    hold_w |=> gnt_q == $past(gnt_q)) else $error("held grant moved"); // R6

  AST_GNT_WAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (|gnt_q) |-> |(gnt_q & $past(req_i))) else $error("grant without request"); // R12

  AST_BLOCK_NO_NEW: assert property (@(posedge clk) disable iff (rst)
    (block_i && !hold_w) |=> gnt_q == '0) else $error("grant while blocked"); // R11

  AST_RR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (issue_w && rr_any) |=> |gnt_q[NRR-1:0]) else $error("fixed group jumped ahead"); // R5

  AST_PTR_STILL: assert property (@(posedge clk) disable iff (rst)
    !(issue_w && rr_any) |=> $stable(ptr_q)) else $error("pointer moved idle"); // R3

endmodule

// File: rtl/hier_bus_arbiter.sv
module hier_bus_arbiter #(
  parameter int BUS_RR = 3,
  parameter int BUS_FX = 2,
  parameter int EXT_RR = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [BUS_RR+BUS_FX-1:0]       req_a,
  input  logic [BUS_RR+BUS_FX-1:0]       req_b,
  input  logic [2*(BUS_RR+BUS_FX)-1:0]   xreq,
  input  logic [1:0]                     burst_hold,
  output logic [BUS_RR+BUS_FX-1:0]       gnt_a,
  output logic [BUS_RR+BUS_FX-1:0]       gnt_b,
  output logic [2*(BUS_RR+BUS_FX)-1:0]   xgnt
);

  localparam int N     = BUS_RR + BUS_FX;
  localparam int XN    = 2 * N;
  localparam int EXTFX = XN - EXT_RR;

  logic [N-1:0] lreq [2];
  logic [N-1:0] lgnt [2];
  logic         int_pend;
  logic         ext_block;

  assign lreq[0] = req_a;
  assign lreq[1] = req_b;

  for (genvar b = 0; b < 2; b++) begin : g_bus
    grp_arb #(.NRR(BUS_RR), .NFX(BUS_FX)) u_bus (
      .clk    (clk),
      .rst    (rst),
      .req_i  (lreq[b]),
      .block_i(burst_hold[b]),
      .gnt_o  (lgnt[b])
    );
  end

  assign gnt_a = lgnt[0];
  assign gnt_b = lgnt[1];

  // cross-bus level waits for both local levels to be quiet
  assign int_pend  = (|req_a) || (|req_b);
  assign ext_block = int_pend || (|burst_hold);

  grp_arb #(.NRR(EXT_RR), .NFX(EXTFX)) u_ext (
    .clk    (clk),
    .rst    (rst),
    .req_i  (xreq),
    .block_i(ext_block),
    .gnt_o  (xgnt)
  );

  AST_XGNT_WAITS: assert property (@(posedge clk) disable iff (rst)
    (int_pend && !(|(xgnt & xreq))) |=> xgnt == '0) else $error("cross grant over local"); // R10

  AST_XGNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(xgnt)) else $error("cross grant not one-hot"); // R7

  AST_HOLD_A_ONLY: assert property (@(posedge clk) disable iff (rst)
    (burst_hold[0] && !(|(gnt_a & req_a))) |=> gnt_a == '0) else $error("bus A grant in hold"); // R11

endmodule

// File: tb/hier_bus_arbiter_tb_top.sv
module hier_bus_arbiter_tb_top;

  localparam int NRR = 3;
  localparam int NFX = 2;
  localparam int N   = NRR + NFX;
  localparam int XRR = 4;
  localparam int XN  = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_a = '0, req_b = '0;
  logic [XN-1:0] xreq = '0;
  logic [1:0]    burst_hold = '0;
  logic [N-1:0]  gnt_a, gnt_b;
  logic [XN-1:0] xgnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N-1:0]  ea;
    logic [N-1:0]  eb;
    logic [XN-1:0] ex;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state
  logic [15:0] m_ga = '0, m_gb = '0, m_gx = '0;
  int p_a = 0, p_b = 0, p_x = 0;

  always #5 clk = ~clk;

  hier_bus_arbiter #(.BUS_RR(NRR), .BUS_FX(NFX), .EXT_RR(XRR)) dut_i (
    .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b), .xreq(xreq),
    .burst_hold(burst_hold), .gnt_a(gnt_a), .gnt_b(gnt_b), .xgnt(xgnt)
  );

  // reference step of one nested arbiter, written from the requirements
  task automatic ref_arb(input logic [15:0] rq, input int n, input int nrr, input bit blk,
                         inout logic [15:0] g, inout int p);
    if ((rq & g) != 0) return;
    g = '0;
    if (blk) return;
    for (int off = 0; off < nrr; off++) begin
      int i;
      i = (p + off) % nrr;
      if (rq[i]) begin
        g[i] = 1'b1;
        p = (i + 1) % nrr;
        return;
      end
    end
    for (int i = nrr; i < n; i++) begin
      if (rq[i]) begin
        g[i] = 1'b1;
        return;
      end
    end
  endtask

  task automatic step(input logic [N-1:0] ra, input logic [N-1:0] rb,
                      input logic [XN-1:0] xr, input logic [1:0] hb, input string tag);
    exp_t e;
    bit xblk;
    @(negedge clk);
    req_a = ra; req_b = rb; xreq = xr; burst_hold = hb;
    #1;
    checks++;
    if (gnt_a !== m_ga[N-1:0] || gnt_b !== m_gb[N-1:0] || xgnt !== m_gx[XN-1:0]) begin
      failures++;
      $display("FAIL R12 grants changed before the edge: a=%b b=%b x=%b expected a=%b b=%b x=%b",
               gnt_a, gnt_b, xgnt, m_ga[N-1:0], m_gb[N-1:0], m_gx[XN-1:0]);
    end
    xblk = (ra != 0) || (rb != 0) || (hb != 0);
    ref_arb(16'(ra), N, NRR, hb[0], m_ga, p_a);
    ref_arb(16'(rb), N, NRR, hb[1], m_gb, p_b);
    ref_arb(16'(xr), XN, XRR, xblk, m_gx, p_x);
    e.ea = m_ga[N-1:0]; e.eb = m_gb[N-1:0]; e.ex = m_gx[XN-1:0]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare one expected item per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (gnt_a !== e.ea || gnt_b !== e.eb || xgnt !== e.ex) begin
          failures++;
          $display("FAIL %s: a=%b b=%b x=%b expected a=%b b=%b x=%b",
                   e.tag, gnt_a, gnt_b, xgnt, e.ea, e.eb, e.ex);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (gnt_a !== '0 || gnt_b !== '0 || xgnt !== '0) begin
      failures++;
      $display("FAIL R1 reset grants: a=%b b=%b x=%b expected all zero", gnt_a, gnt_b, xgnt);
    end

    // round-robin on bus A
    step(5'b00111, '0, '0, 2'b00, "R1 first rr grant at index 0");
    step(5'b00110, '0, '0, 2'b00, "R2 next member after drop");
    step(5'b00101, '0, '0, 2'b00, "R2 scan upward");
    step(5'b00011, '0, '0, 2'b00, "R2 wrap past top");
    step(5'b00000, '0, '0, 2'b00, "R6 grant released");
    // fixed group and group order
    step(5'b11000, '0, '0, 2'b00, "R4 lowest fixed index");
    step(5'b11100, '0, '0, 2'b00, "R6 held over rr arrival");
    step(5'b10100, '0, '0, 2'b00, "R5 rr group outranks fixed");
    // burst hold and pointer
    step(5'b10000, '0, '0, 2'b01, "R11 no new grant in hold");
    step(5'b10111, '0, '0, 2'b01, "R3 pointer still in hold");
    step(5'b10111, '0, '0, 2'b01, "R11 hold continues");
    step(5'b10111, '0, '0, 2'b00, "R3 winner shows unchanged pointer");
    // both buses
    step(5'b10111, 5'b01001, '0, 2'b00, "R8 both buses granted");
    step(5'b00100, 5'b00100, '0, 2'b10, "R8 hold on B leaves A");
    // cross-bus level
    step(5'b00100, 5'b00000, 10'b0000000100, 2'b00, "R10 cross waits for local");
    step(5'b00000, 5'b00000, 10'b0000000100, 2'b00, "R9 cross rr grant");
    step(5'b00010, 5'b00000, 10'b0000000100, 2'b00, "R10 cross grant kept");
    step(5'b00000, 5'b00000, 10'b0100000000, 2'b00, "R9 cross fixed from bus B");
    step(5'b00000, 5'b00000, 10'b0100000000, 2'b10, "R11 cross held in hold");
    step(5'b00000, 5'b00000, 10'b0000101000, 2'b10, "R11 no new cross grant in hold");
    step(5'b00000, 5'b00000, 10'b0000101000, 2'b00, "R9 cross pointer order");
    step(5'b00000, 5'b00000, 10'b0000100000, 2'b00, "R7 single cross grant");
    step(5'b00000, 5'b00000, 10'b0000000000, 2'b00, "R6 cross released");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R12 scoreboard left %0d items, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule